// File: doc/BRIEF.md
# DMA Controller Register Interface

This block is the register file that a processor sees on a four-channel DMA controller. The processor reaches it over an 8-bit port bus with separate write and read strobes. A 4-bit port index is split into two halves. The lower half is the channel space, which holds a 16-bit base address and a 16-bit base count for each channel. The upper half is the control space, which holds the command, the software request, the mask, the mode, and several data-less commands such as master reset.

Sixteen-bit values move one byte per access. A single byte pointer, shared by all channels, decides which byte is used. Writing the high byte of a base register copies both base values of that channel into its current address and current count registers. In the same step the block pulses a per-channel load strobe to the transfer engine. The transfer engine reports terminal counts back through a set input.

A parameter selects a word-wide variant. In that variant the port index comes from address bits one position higher, and the current registers hold the base values doubled.

Top module: `dma_regfile`

## Requirements
- R1: The port index is `busAddr[WORD_WIDE +: 4]`. When index bit 3 is 0 the access goes to the channel space: the channel is index bits 2:1, and index bit 0 selects the address register (0) or the count register (1). When index bit 3 is 1 the access goes to control port number index bits 2:0.
- R2: The byte pointer is 0 after reset. Each channel-space read or write uses the low byte when the pointer is 0 and the high byte when it is 1, and then inverts the pointer.
- R3: A high-byte write reloads the channel's current address and current count from its two base registers, each multiplied by 2^WORD_WIDE. The matching bit of `loadStb` is high for exactly the one cycle after that write. A low-byte write raises no strobe.
- R4: A command write (port 0) whose data has any bit of 0xFB set is rejected. `cmdReg` keeps its value and `cmdUnsupported` is high for the one cycle after the write. Any other value is stored.
- R5: A port 1 write selects a channel with data bits 1:0. Data bit 2 then sets (1) or clears (0) that channel's request bit, which is `reqBits` and also status bits 7:4.
- R6: A port 2 write selects a channel with data bits 1:0. Data bit 2 set masks that channel, and bit 2 clear unmasks it.
- R7: A port 3 write stores the whole data byte as the mode of the channel given by data bits 1:0. The mode sits at `modeFlat[8*ch +: 8]`, with transfer type in bits 3:2, auto-initialize in bit 4, address decrement in bit 5 and operating mode in bits 7:6. The modes of the other channels do not change.
- R8: A port 4 write clears the byte pointer, whatever the data. A port 6 write clears all four mask bits, whatever the data. A port 7 write loads the mask from data bits 3:0.
- R9: `busRdData` is valid in the cycle after `busRd`. Control port 0 reads `{request[3:0], terminal count[3:0]}`, port 1 reads `{4'b0, mask}`, and ports 2 to 7 read 0. A channel read returns the selected byte of the current register divided by 2^WORD_WIDE.
- R10: Asserting `rstN` low, or writing port 5 with any data, sets all mask bits and clears the byte pointer, the command register and all status bits.
- R11: Reading port 0 clears the terminal-count bits and leaves the request bits as they are. A `tcSet` bit sets its terminal-count bit, and it wins over a clear made by a status read in the same cycle.
- R12: With WORD_WIDE=1, `busAddr` bit 0 is ignored and the current registers hold twice the base value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWr | input | 1 | Write strobe for one cycle |
| busRd | input | 1 | Read strobe for one cycle (ignored together with busWr) |
| busAddr | input | 4+WORD_WIDE | Port address |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Read data, valid the cycle after busRd |
| tcSet | input | 4 | Terminal-count set from the transfer engine |
| curAddrFlat | output | 4*(16+WORD_WIDE) | Current address of each channel |
| curCountFlat | output | 4*(16+WORD_WIDE) | Current count of each channel |
| modeFlat | output | 32 | Mode byte of each channel |
| maskBits | output | 4 | Channel mask |
| reqBits | output | 4 | Software request bits |
| cmdReg | output | 8 | Command register |
| loadStb | output | 4 | One-cycle reload strobe for each channel |
| cmdUnsupported | output | 1 | One-cycle flag for a rejected command |

## Verification
Every register result of a write, and every read byte, is due one clock edge after the strobe. `loadStb` and `cmdUnsupported` are high only in that following cycle. The bench drives each access on a falling edge and samples on the next falling edge, so it sees exactly the cycle in which each result becomes valid. It samples once more a cycle later to confirm that the pulses have dropped. Tests of the byte pointer and of status side effects chain several accesses, because each access changes the state that the next one depends on.

// File: rtl/dma_regfile_pkg.sv
package dma_regfile_pkg;
  localparam int NUM_CH = 4;
  localparam int REG_W  = 16;
  localparam int BYTE_W = 8;

  // control port numbers
  localparam logic [2:0] P_CMD    = 3'd0;
  localparam logic [2:0] P_SWREQ  = 3'd1;
  localparam logic [2:0] P_SMASK  = 3'd2;
  localparam logic [2:0] P_MODE   = 3'd3;
  localparam logic [2:0] P_CLRPTR = 3'd4;
  localparam logic [2:0] P_MRESET = 3'd5;
  localparam logic [2:0] P_CLRMSK = 3'd6;
  localparam logic [2:0] P_WRMSK  = 3'd7;

  // command bits this register interface refuses to hold
  localparam logic [BYTE_W-1:0] CMD_REJECT_MASK = 8'hFB;

  typedef struct packed {
    logic       wrLo;
    logic       wrHi;
    logic       wrMode;
    logic [1:0] chan;
    logic       selCount;
    logic       rdHi;
  } chanStrobe_t;
endpackage

// File: rtl/dma_regfile_ctrl.sv
module dma_regfile_ctrl
  import dma_regfile_pkg::*;
#(
  parameter int WORD_WIDE = 0,
  localparam int ADDR_W = 4 + WORD_WIDE
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [BYTE_W-1:0] busWrData,
  input  logic [NUM_CH-1:0] tcSet,
  input  logic [BYTE_W-1:0] chanRdByte,
  output chanStrobe_t       stb,
  output logic [BYTE_W-1:0] busRdData,
  output logic [NUM_CH-1:0] maskBits,
  output logic [NUM_CH-1:0] reqBits,
  output logic [BYTE_W-1:0] cmdReg,
  output logic              cmdUnsupported
);
  logic [3:0]        portIdx;
  logic              isCtl;
  logic              wrAct;
  logic              rdAct;
  logic              chanAcc;
  logic              statusRd;
  logic [7:0]        portWr;
  logic              bytePtr;
  logic [NUM_CH-1:0] tcBits;
  logic              cmdBad;

  always_comb begin
    portIdx  = busAddr[WORD_WIDE +: 4];
    isCtl    = portIdx[3];
    wrAct    = busWr;
    rdAct    = busRd && !busWr;
    chanAcc  = (wrAct || rdAct) && !isCtl;
    statusRd = rdAct && isCtl && (portIdx[2:0] == P_CMD);
    for (int k = 0; k < 8; k++) begin
      portWr[k] = wrAct && isCtl && (portIdx[2:0] == 3'(k));
    end
    cmdBad = (busWrData & CMD_REJECT_MASK) != '0;

    stb          = '0;
    stb.wrLo     = wrAct && !isCtl && !bytePtr;
    stb.wrHi     = wrAct && !isCtl && bytePtr;
    stb.wrMode   = portWr[P_MODE];
    stb.chan     = isCtl ? busWrData[1:0] : portIdx[2:1];
    stb.selCount = portIdx[0];
    stb.rdHi     = bytePtr;
  end

  // byte pointer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                   bytePtr <= 1'b0;
    else if (portWr[P_CLRPTR] || portWr[P_MRESET]) bytePtr <= 1'b0;
    else if (chanAcc)                            bytePtr <= !bytePtr;
  end

  // command register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdReg         <= '0;
      cmdUnsupported <= 1'b0;
    end else begin
      cmdUnsupported <= portWr[P_CMD] && cmdBad;
      if (portWr[P_MRESET])              cmdReg <= '0;
      else if (portWr[P_CMD] && !cmdBad) cmdReg <= busWrData;
    end
  end

  // mask register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  maskBits <= '1;
    else if (portWr[P_MRESET])  maskBits <= '1;
    else if (portWr[P_CLRMSK])  maskBits <= '0;
    else if (portWr[P_WRMSK])   maskBits <= busWrData[NUM_CH-1:0];
    else if (portWr[P_SMASK])   maskBits[busWrData[1:0]] <= busWrData[2];
  end

  // status: terminal counts and requests
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tcBits  <= '0;
      reqBits <= '0;
    end else if (portWr[P_MRESET]) begin
      tcBits  <= '0;
      reqBits <= '0;
    end else begin
      tcBits <= (statusRd ? '0 : tcBits) | tcSet;
      if (portWr[P_SWREQ]) reqBits[busWrData[1:0]] <= busWrData[2];
    end
  end

  // read data register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) busRdData <= '0;
    else if (rdAct) begin
      if (!isCtl)                          busRdData <= chanRdByte;
      else if (portIdx[2:0] == P_CMD)      busRdData <= {reqBits, tcBits};
      else if (portIdx[2:0] == P_SWREQ)    busRdData <= {4'b0, maskBits};
      else                                 busRdData <= '0;
    end
  end

  assert_ptr_toggle_R2: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) && $past(chanAcc) |-> bytePtr != $past(bytePtr));

  assert_cmd_reject_R4: assert property (@(posedge clk) disable iff (!rstN)
    cmdUnsupported |-> $stable(cmdReg));

  assert_single_mask_R6: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) && $past(portWr[P_SMASK]) && !$past(portWr[P_MRESET])
      |-> maskBits[$past(busWrData[1:0])] == $past(busWrData[2]));

  assert_master_reset_R10: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) && $past(portWr[P_MRESET])
      |-> maskBits == 4'hF && cmdReg == 8'h00 && reqBits == 4'h0 && !bytePtr);

  assert_status_clear_R11: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) && $past(statusRd) && $past(tcSet) == 4'h0
      |-> tcBits == 4'h0 && reqBits == $past(reqBits));
endmodule

// File: rtl/dma_regfile_chdp.sv
module dma_regfile_chdp
  import dma_regfile_pkg::*;
#(
  parameter int WORD_WIDE = 0,
  localparam int CUR_W = REG_W + WORD_WIDE
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  chanStrobe_t             stb,
  input  logic [BYTE_W-1:0]       wrData,
  output logic [NUM_CH*CUR_W-1:0] curAddrFlat,
  output logic [NUM_CH*CUR_W-1:0] curCountFlat,
  output logic [NUM_CH*8-1:0]     modeFlat,
  output logic [NUM_CH-1:0]       loadStb,
  output logic [BYTE_W-1:0]       rdByte
);
  logic [NUM_CH-1:0][CUR_W-1:0] curAArr;
  logic [NUM_CH-1:0][CUR_W-1:0] curCArr;

  for (genvar g = 0; g < NUM_CH; g++) begin : gCh
    logic [REG_W-1:0] baseAddr;
    logic [REG_W-1:0] baseCount;
    logic [CUR_W-1:0] curA;
    logic [CUR_W-1:0] curC;
    logic [7:0]       mode;
    logic             loadQ;
    logic             selHere;
    logic [REG_W-1:0] nextA;
    logic [REG_W-1:0] nextC;

    always_comb begin
      selHere = (stb.chan == 2'(g));
      nextA   = stb.selCount ? baseAddr : {wrData, baseAddr[7:0]};
      nextC   = stb.selCount ? {wrData, baseCount[7:0]} : baseCount;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        baseAddr  <= '0;
        baseCount <= '0;
        curA      <= '0;
        curC      <= '0;
        mode      <= '0;
        loadQ     <= 1'b0;
      end else begin
        loadQ <= 1'b0;
        if (selHere && stb.wrLo) begin
          if (stb.selCount) baseCount[7:0] <= wrData;
          else              baseAddr[7:0]  <= wrData;
        end
        if (selHere && stb.wrHi) begin
          baseAddr  <= nextA;
          baseCount <= nextC;
          curA      <= CUR_W'(nextA) << WORD_WIDE;
          curC      <= CUR_W'(nextC) << WORD_WIDE;
          loadQ     <= 1'b1;
        end
        if (selHere && stb.wrMode) mode <= wrData;
      end
    end

    assign curAArr[g]          = curA;
    assign curCArr[g]          = curC;
    assign modeFlat[8*g +: 8]  = mode;
    assign loadStb[g]          = loadQ;

    assert_reload_R3: assert property (@(posedge clk) disable iff (!rstN)
      loadQ |-> curA == (CUR_W'(baseAddr) << WORD_WIDE)
             && curC == (CUR_W'(baseCount) << WORD_WIDE));
  end

  assign curAddrFlat  = curAArr;
  assign curCountFlat = curCArr;

  logic [CUR_W-1:0] rdSel;
  logic [REG_W-1:0] rdScaled;
  always_comb begin
    rdSel    = stb.selCount ? curCArr[stb.chan] : curAArr[stb.chan];
    rdScaled = REG_W'(rdSel >> WORD_WIDE);
    rdByte   = stb.rdHi ? rdScaled[15:8] : rdScaled[7:0];
  end

  assert_load_onehot_R3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(loadStb));
endmodule

// File: rtl/dma_regfile.sv
module dma_regfile
  import dma_regfile_pkg::*;
#(
  parameter int WORD_WIDE = 0,
  localparam int ADDR_W = 4 + WORD_WIDE,
  localparam int CUR_W  = 16 + WORD_WIDE
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                busWr,
  input  logic                busRd,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic [7:0]          busWrData,
  output logic [7:0]          busRdData,
  input  logic [3:0]          tcSet,
  output logic [4*CUR_W-1:0]  curAddrFlat,
  output logic [4*CUR_W-1:0]  curCountFlat,
  output logic [31:0]         modeFlat,
  output logic [3:0]          maskBits,
  output logic [3:0]          reqBits,
  output logic [7:0]          cmdReg,
  output logic [3:0]          loadStb,
  output logic                cmdUnsupported
);
  chanStrobe_t chStb;
  logic [7:0]  chRdByte;

  dma_regfile_ctrl #(.WORD_WIDE(WORD_WIDE)) u_ctrl (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busRd(busRd), .busAddr(busAddr),
    .busWrData(busWrData), .tcSet(tcSet), .chanRdByte(chRdByte), .stb(chStb),
    .busRdData(busRdData), .maskBits(maskBits), .reqBits(reqBits),
    .cmdReg(cmdReg), .cmdUnsupported(cmdUnsupported)
  );

  dma_regfile_chdp #(.WORD_WIDE(WORD_WIDE)) u_chdp (
    .clk(clk), .rstN(rstN), .stb(chStb), .wrData(busWrData),
    .curAddrFlat(curAddrFlat), .curCountFlat(curCountFlat),
    .modeFlat(modeFlat), .loadStb(loadStb), .rdByte(chRdByte)
  );
endmodule

// File: tb/dma_regfile_bench.sv
module dma_regfile_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #5 clk = !clk;

  int checks = 0;
  int failures = 0;

  // narrow instance
  logic        busWr = 0, busRd = 0;
  logic [3:0]  busAddr = '0;
  logic [7:0]  busWrData = '0;
  logic [7:0]  busRdData;
  logic [3:0]  tcSet = '0;
  logic [63:0] curAddrFlat, curCountFlat;
  logic [31:0] modeFlat;
  logic [3:0]  maskBits, reqBits, loadStb;
  logic [7:0]  cmdReg;
  logic        cmdUnsupported;

  dma_regfile u_dma_regfile (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busRd(busRd), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .tcSet(tcSet),
    .curAddrFlat(curAddrFlat), .curCountFlat(curCountFlat), .modeFlat(modeFlat),
    .maskBits(maskBits), .reqBits(reqBits), .cmdReg(cmdReg), .loadStb(loadStb),
    .cmdUnsupported(cmdUnsupported)
  );

  // word-wide instance
  logic        wBusWr = 0, wBusRd = 0;
  logic [4:0]  wBusAddr = '0;
  logic [7:0]  wBusWrData = '0;
  logic [7:0]  wBusRdData;
  logic [67:0] wCurAddrFlat, wCurCountFlat;
  logic [31:0] wModeFlat;
  logic [3:0]  wMaskBits, wReqBits, wLoadStb;
  logic [7:0]  wCmdReg;
  logic        wCmdUnsupported;

  dma_regfile #(.WORD_WIDE(1)) u_dma_regfile_w (
    .clk(clk), .rstN(rstN), .busWr(wBusWr), .busRd(wBusRd), .busAddr(wBusAddr),
    .busWrData(wBusWrData), .busRdData(wBusRdData), .tcSet(4'h0),
    .curAddrFlat(wCurAddrFlat), .curCountFlat(wCurCountFlat), .modeFlat(wModeFlat),
    .maskBits(wMaskBits), .reqBits(wReqBits), .cmdReg(wCmdReg), .loadStb(wLoadStb),
    .cmdUnsupported(wCmdUnsupported)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] idx, input logic [7:0] d);
    busAddr = idx; busWrData = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] idx, output logic [7:0] d);
    busAddr = idx; busRd = 1'b1;
    @(negedge clk);
    busRd = 1'b0;
    d = busRdData;
  endtask

  task automatic wwr(input logic [3:0] idx, input logic [7:0] d);
    wBusAddr = {idx, 1'b1}; wBusWrData = d; wBusWr = 1'b1;
    @(negedge clk);
    wBusWr = 1'b0;
  endtask

  task automatic wrd(input logic [3:0] idx, output logic [7:0] d);
    wBusAddr = {idx, 1'b0}; wBusRd = 1'b1;
    @(negedge clk);
    wBusRd = 1'b0;
    d = wBusRdData;
  endtask

  task automatic test_reset();
    logic [7:0] d;
    chk("R10 reset mask", maskBits, 4'hF);
    chk("R10 reset cmd", cmdReg, 0);
    chk("R10 reset req", reqBits, 0);
    rd(4'd8, d);
    chk("R9 reset status read", d, 0);
  endtask

  task automatic test_base_write();
    logic [7:0] d;
    wr(4'd2, 8'h34);
    chk("R2 low byte no strobe", loadStb, 0);
    wr(4'd2, 8'h12);
    chk("R3 load strobe ch1", loadStb, 4'b0010);
    chk("R3 ch1 current address", curAddrFlat[16 +: 16], 16'h1234);
    @(negedge clk);
    chk("R3 strobe one cycle", loadStb, 0);
    rd(4'd2, d);
    chk("R2 read low byte", d, 8'h34);
    rd(4'd2, d);
    chk("R2 read high byte", d, 8'h12);
  endtask

  task automatic test_count();
    wr(4'd7, 8'hCD);
    wr(4'd7, 8'hAB);
    chk("R1 ch3 current count", curCountFlat[48 +: 16], 16'hABCD);
    chk("R1 ch3 address untouched", curAddrFlat[48 +: 16], 0);
    chk("R3 load strobe ch3", loadStb, 4'b1000);
  endtask

  task automatic test_clear_ptr();
    wr(4'd0, 8'h11);
    wr(4'd12, 8'h99);
    wr(4'd0, 8'h22);
    wr(4'd0, 8'h33);
    chk("R8 pointer clear ch0 address", curAddrFlat[0 +: 16], 16'h3322);
  endtask

  task automatic test_command();
    wr(4'd8, 8'h04);
    chk("R4 command stored", cmdReg, 8'h04);
    chk("R4 no flag on legal command", cmdUnsupported, 0);
    wr(4'd8, 8'h10);
    chk("R4 flag on illegal command", cmdUnsupported, 1);
    chk("R4 command kept", cmdReg, 8'h04);
    @(negedge clk);
    chk("R4 flag one cycle", cmdUnsupported, 0);
    wr(4'd8, 8'h00);
    chk("R4 zero command stored", cmdReg, 0);
  endtask

  task automatic test_swreq();
    logic [7:0] d;
    wr(4'd9, 8'h06);
    chk("R5 request ch2 set", reqBits, 4'b0100);
    rd(4'd8, d);
    chk("R5 request in status", d, 8'h40);
    wr(4'd9, 8'h02);
    chk("R5 request ch2 cleared", reqBits, 0);
  endtask

  task automatic test_masks();
    logic [7:0] d;
    wr(4'd10, 8'h01);
    chk("R6 unmask ch1", maskBits, 4'b1101);
    wr(4'd10, 8'h05);
    chk("R6 mask ch1", maskBits, 4'b1111);
    wr(4'd14, 8'h3C);
    chk("R8 clear all masks", maskBits, 0);
    wr(4'd15, 8'hFA);
    chk("R8 write all masks", maskBits, 4'hA);
    rd(4'd9, d);
    chk("R9 mask read", d, 8'h0A);
  endtask

  task automatic test_mode();
    wr(4'd11, 8'hB6);
    chk("R7 mode ch2", modeFlat[16 +: 8], 8'hB6);
    chk("R7 mode ch0 untouched", modeFlat[0 +: 8], 0);
  endtask

  task automatic test_tc();
    logic [7:0] d;
    tcSet = 4'b1001;
    @(negedge clk);
    tcSet = 4'b0000;
    wr(4'd9, 8'h07);
    rd(4'd8, d);
    chk("R11 status with tc and request", d, 8'h89);
    rd(4'd8, d);
    chk("R11 tc cleared request kept", d, 8'h80);
    tcSet = 4'b0001;
    rd(4'd8, d);
    tcSet = 4'b0000;
    chk("R11 read during set", d, 8'h80);
    rd(4'd8, d);
    chk("R11 set wins over clear", d, 8'h81);
  endtask

  task automatic test_master_reset();
    logic [7:0] d;
    wr(4'd8, 8'h04);
    wr(4'd15, 8'h00);
    wr(4'd9, 8'h05);
    wr(4'd0, 8'h77);
    wr(4'd13, 8'h5A);
    chk("R10 master reset mask", maskBits, 4'hF);
    chk("R10 master reset cmd", cmdReg, 0);
    chk("R10 master reset req", reqBits, 0);
    rd(4'd8, d);
    chk("R10 master reset status", d, 0);
    wr(4'd0, 8'h55);
    wr(4'd0, 8'h66);
    chk("R10 pointer cleared by reset", curAddrFlat[0 +: 16], 16'h6655);
    chk("R10 load after reset", loadStb, 4'b0001);
  endtask

  task automatic test_other_read();
    logic [7:0] d;
    rd(4'd12, d);
    chk("R9 port 4 reads zero", d, 0);
    rd(4'd14, d);
    chk("R9 port 6 reads zero", d, 0);
  endtask

  task automatic test_wide();
    logic [7:0] d;
    wwr(4'd3, 8'h10);
    wwr(4'd3, 8'h02);
    chk("R12 wide count doubled", wCurCountFlat[17 +: 17], 17'h00420);
    chk("R12 wide load strobe", wLoadStb, 4'b0010);
    wrd(4'd3, d);
    chk("R12 wide read low", d, 8'h10);
    wrd(4'd3, d);
    chk("R12 wide read high", d, 8'h02);
    wwr(4'd15, 8'h05);
    chk("R12 wide mask port", wMaskBits, 4'b0101);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    test_reset();
    test_base_write();
    test_count();
    test_clear_ptr();
    test_command();
    test_swreq();
    test_masks();
    test_mode();
    test_tc();
    test_master_reset();
    test_other_read();
    test_wide();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #2000000;
    checks++;
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule